// File: doc/BRIEF.md
# Mode-Selectable Lane-Partitioned Adder

This block adds two 64-bit operand words element by element. Each operation carries a 2-bit lane mode that chooses, for that operation alone, how the word is split. The choices are one 64-bit element, two 32-bit elements, four 16-bit elements or eight 8-bit elements. A single add therefore gives one result per element pair, and all the results come back packed in one output word. The widest setting is ordinary scalar addition.

The datapath is a chain of 8-bit slices. A small decoder turns the lane mode into a cut mask that stops the carry at each slice boundary that is also a lane boundary. Every lane then wraps modulo its own width and does not depend on its neighbours. One register stage holds the sum. The output valid follows the input valid by the same single cycle.

The block has no control state beyond that register, so the house style's state machine reduces to one register process. It has two named conditions. Capture happens when `in_valid` is high at a clock edge. Hold happens when `in_valid` is low. The only transition is capture to hold and back, and it follows `in_valid` on each cycle.

Top module: `simd_lane_adder`

## Requirements
- R1: Mode code 00 gives one 64-bit lane: `out_sum` = (`in_a` + `in_b`) mod 2^64.
- R2: Mode code 01 gives two 32-bit lanes. Each lane is the sum of the matching operand lanes mod 2^32, and no carry passes from lane 0 into lane 1.
- R3: Mode code 10 gives four 16-bit lanes. Each lane is computed independently mod 2^16, with no carry across any 16-bit boundary.
- R4: Mode code 11 gives eight 8-bit lanes. Each lane is computed independently mod 2^8.
- R5: Lanes are packed little-endian: lane i of width W occupies bits [i*W +: W] of operands and result, so lane 0 is in the least significant bits.
- R6: A sum presented with `in_valid` high at a clock edge appears on `out_sum` after that edge. `out_valid` is high for exactly the cycles that follow an edge with `in_valid` high.
- R7: While `in_valid` is low, `out_sum` keeps its last value whatever the operands and mode do, and `out_valid` is low.
- R8: After reset, `out_valid` is 0 and `out_sum` is 0.
- R9: The mode can change on every back-to-back operation. Each result uses the mode presented with its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_mode | input | 2 | Lane mode: 00=1x64, 01=2x32, 10=4x16, 11=8x8 |
| in_a | input | 64 | First operand word |
| in_b | input | 64 | Second operand word |
| out_valid | output | 1 | Registered result is new this cycle |
| out_sum | output | 64 | Registered packed lane sums |

## Verification
The case that is hardest to reach from the ports is a carry that would run across a lane boundary and through every slice above it. Only this case separates a correctly cut chain from one that is cut in the wrong place. Random operands seldom make long propagate runs, so directed words are added to the random stream. These words are all-ones plus one, 0x80 in every byte, and all-ones plus all-ones, and each of them is sent in every mode. Back-to-back operations whose mode changes on every cycle show that the cut mask follows the operation and not a stale setting.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    // Slice geometry: the word is built from SLICE_CNT slices of SLICE_W bits.
    localparam int SLICE_W   = 8;
    localparam int SLICE_CNT = 8;
    localparam int WORD_W    = SLICE_W * SLICE_CNT;

    // Lane mode encoding: each step up halves the lane width.
    typedef enum logic [1:0] {
        LANE_64 = 2'b00,
        LANE_32 = 2'b01,
        LANE_16 = 2'b10,
        LANE_8  = 2'b11
    } lane_mode_e;

endpackage

// File: rtl/simd_carry_cut.sv
module simd_carry_cut
    import simd_add_pkg::*;
#(
    parameter int SLICES = SLICE_CNT
) (
    input  lane_mode_e          mode,
    output logic [SLICES-2:0]   cut
);

    // Number of slices in one lane for the selected mode.
    int span;

    always_comb begin
        unique case (mode)
            LANE_64: span = SLICES;
            LANE_32: span = SLICES / 2;
            LANE_16: span = SLICES / 4;
            LANE_8:  span = SLICES / 8;
            default: span = SLICES;
        endcase
        // Boundary k sits above slice k; cut it when it ends a lane.
        for (int k = 0; k < SLICES - 1; k++) begin
            cut[k] = (((k + 1) & (span - 1)) == 0);
        end
    end

endmodule

// File: rtl/simd_add_slice.sv
module simd_add_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] full;

    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];

endmodule

// File: rtl/simd_partitioned_sum.sv
module simd_partitioned_sum
    import simd_add_pkg::*;
#(
    parameter int SW = SLICE_W,
    parameter int SN = SLICE_CNT,
    localparam int DW = SW * SN
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [SN-2:0] cut,
    output logic [DW-1:0] sum
);

    logic [SN-1:0] cin;
    logic [SN-2:0] cout;

    assign cin[0] = 1'b0;

    for (genvar k = 0; k < SN; k++) begin : g_slice
        if (k < SN - 1) begin : g_mid
            simd_add_slice #(.W(SW)) u_slice (
                .a    (a[k*SW +: SW]),
                .b    (b[k*SW +: SW]),
                .cin  (cin[k]),
                .sum  (sum[k*SW +: SW]),
                .cout (cout[k])
            );
            // A lane boundary kills the carry into the next slice.
            assign cin[k+1] = cout[k] & ~cut[k];
        end else begin : g_top
            // Top slice: its carry-out leaves the word and is dropped.
            assign sum[k*SW +: SW] = a[k*SW +: SW] + b[k*SW +: SW] + {{(SW-1){1'b0}}, cin[k]};
        end
    end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_add_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic [WORD_W-1:0]  in_a,
    input  logic [WORD_W-1:0]  in_b,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_sum
);

    lane_mode_e           mode_q;
    logic [SLICE_CNT-2:0] cut;
    logic [WORD_W-1:0]    sum_d;

    assign mode_q = lane_mode_e'(in_mode);

    simd_carry_cut #(.SLICES(SLICE_CNT)) u_cut (
        .mode (mode_q),
        .cut  (cut)
    );

    simd_partitioned_sum #(.SW(SLICE_W), .SN(SLICE_CNT)) u_sum (
        .a   (in_a),
        .b   (in_b),
        .cut (cut),
        .sum (sum_d)
    );

    // Result register: captures on valid, holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sum <= sum_d;
            end
        end
    end

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sum)));

    assert_scalar_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00) |=> (out_sum == $past(in_a + in_b)));

    assert_upper_half_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=>
            (out_sum[63:32] == $past(32'(in_a[63:32] + in_b[63:32]))));

    assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11) |=>
            (out_sum[15:8] == $past(8'(in_a[15:8] + in_b[15:8]))));

endmodule

// File: tb/tb_simd_lane_adder.sv
module tb_simd_lane_adder;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic [63:0] in_a;
    logic [63:0] in_b;
    logic        out_valid;
    logic [63:0] out_sum;

    int checks;
    int errors;

    simd_lane_adder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: lane width 64 >> mode, lane i at bits [i*W +: W], each wraps.
    function automatic logic [63:0] ref_sum(logic [63:0] a, logic [63:0] b, logic [1:0] m);
        int          lw;
        logic [63:0] mask;
        logic [63:0] res;
        lw   = 64 >> m;
        mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        res  = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            logic [63:0] la;
            logic [63:0] lb;
            la  = (a >> (i * lw)) & mask;
            lb  = (b >> (i * lw)) & mask;
            res = res | (((la + lb) & mask) << (i * lw));
        end
        return res;
    endfunction

    function automatic string req_of(logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check_val(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One isolated operation: drive at negedge, check at the next negedge.
    task automatic one_op(logic [63:0] a, logic [63:0] b, logic [1:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_mode = m;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R6", {63'd0, out_valid}, 64'd1);
        check_val(req_of(m), out_sum, ref_sum(a, b, m));
    endtask

    initial begin
        logic [63:0] exp_q;
        logic [63:0] held;
        checks = 0; errors = 0;
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check_val("R8", {63'd0, out_valid}, 64'd0);
        check_val("R8", out_sum, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed carry-boundary corners in every mode (R1..R4, R5 packing).
        for (int m = 0; m < 4; m++) begin
            one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'(m));
            one_op(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'(m));
            one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'(m));
            one_op(64'h00FF_00FF_FFFF_0000, 64'h0001_0001_0001_FFFF, 2'(m));
        end
        // R5: lane 0 sits in the low bits (distinct per-lane values, 16-bit mode)
        one_op(64'h0004_0003_0002_0001, 64'h0040_0030_0020_0010, 2'b10);
        check_val("R5", out_sum, 64'h0044_0033_0022_0011);

        // Random operations, isolated.
        for (int n = 0; n < 200; n++) begin
            one_op({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom_range(0, 3)));
        end

        // R7: idle cycles with garbage inputs leave the result and valid alone.
        held = out_sum;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            in_valid = 1'b0; in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
            in_mode = 2'($urandom_range(0, 3));
            @(negedge clk);
            check_val("R7", out_sum, held);
            check_val("R7", {63'd0, out_valid}, 64'd0);
        end

        // R9: back-to-back stream, mode changes every cycle.
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b00;
        in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'd1;
        exp_q = ref_sum(in_a, in_b, in_mode);
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            check_val("R9", out_sum, exp_q);
            check_val("R6", {63'd0, out_valid}, 64'd1);
            in_mode = 2'((n + 1) % 4);
            in_a = (n % 5 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
            in_b = (n % 5 == 0) ? 64'd1 : {$urandom, $urandom};
            exp_q = ref_sum(in_a, in_b, in_mode);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R9", out_sum, exp_q);
        @(negedge clk);
        check_val("R6", {63'd0, out_valid}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL R6: watchdog expired, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule